// File: doc/BRIEF.md
# Negative Delta-V Cell Test Unit

This unit sits beside the fast-charge sequencer of a single-cell NiMH charger. While fast charge is enabled it starts a cell test once per test interval. Each test first takes a voltage sample with charge current still flowing (the loaded reading). It then asks the charge gate to hold current off, waits a fixed settling time, and takes a second sample with no current flowing (the open-circuit reading). Both samples come from an external converter through a request/ready handshake, in millivolts.

From the open-circuit reading the unit keeps a running peak. Fast charge ends when a reading falls more than 2 mV below that peak, or when no reading has risen above the peak for a plateau period. Both end conditions are held off for a start-up window after enable. Independently of the hold-off, a loaded-minus-open gap above a programmable threshold reports a high-impedance cell, and an open-circuit reading above 1650 mV reports over-voltage. Each test ends with at most one single-cycle verdict pulse to the sequencer.

All times are counted in `tick` pulses, nominally one per second. The defaults are 31 s between tests, a 240 s hold-off, a 960 s plateau and a 1 s settling delay.

Top module: `dv_cell_test`

## Requirements
- R1: With `en` high, the first test starts on the INTERVAL-th `tick` counted from enable, and later tests start every INTERVAL ticks after that. A test start is shown by `smp_req` rising with `inhibit` low.
- R2: Each test requests the loaded sample while `inhibit` is low. `inhibit` rises in the cycle after that sample is accepted and stays high for the rest of the test. The open-circuit sample is requested only after SETTLE ticks have been seen with `inhibit` high. Verdict pulses appear in the first cycle that `inhibit` is low again.
- R3: `smp_req` stays high until `smp_ready` is seen high. The sample is taken from `smp_mv` in the cycle where both are high.
- R4: The peak is the highest open-circuit reading since enable. `done_pulse` fires when a reading is more than DROP_MV (2) below the peak. A drop of exactly 2 mV does not fire it.
- R5: `done_pulse` fires when a test's reading does not exceed the peak and PLATEAU ticks have passed since the last reading that set a new peak. A new peak restarts this period.
- R6: Neither end condition of R4 or R5 can fire `done_pulse` before HOLDOFF ticks have passed since enable.
- R7: `imp_fail_pulse` fires when the loaded reading exceeds the open-circuit reading by more than `imp_thr_mv`. A gap equal to the threshold does not fire it. The hold-off does not apply.
- R8: `ov_fail_pulse` fires when the open-circuit reading is above OV_MV (1650). The loaded reading plays no part in this check.
- R9: At most one of the three pulses fires per test. Over-voltage wins over impedance, and either fail wins over done.
- R10: While `en` is low, the peak and all timers are cleared, and a test in progress is abandoned: `inhibit` and `smp_req` are low from the next cycle on.
- R11: While `rst` is high and in the cycle after it is released, `smp_req`, `inhibit` and all three pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Fast charge active |
| tick | input | 1 | One-cycle time-base pulse |
| imp_thr_mv | input | 12 | Impedance threshold in mV, 32 to 400 in use |
| smp_req | output | 1 | Voltage sample request |
| smp_ready | input | 1 | Sample valid on `smp_mv` |
| smp_mv | input | 12 | Cell voltage sample in mV |
| inhibit | output | 1 | Charge current held off |
| done_pulse | output | 1 | Fast charge complete |
| imp_fail_pulse | output | 1 | Cell impedance too high |
| ov_fail_pulse | output | 1 | Open-circuit voltage too high |

## Verification
The bench builds the unit with a 6-tick interval, a 15-tick hold-off, a 30-tick plateau and a 1-tick settling delay, and drives a tick every 4 clocks. At these values a hold-off that ends between the second and third test, and a plateau that runs out after the sixth test, can both be reached in a few hundred cycles. The same holds for the exact start-of-test tick count and for the boundary readings (a 2 mV drop, a gap equal to the threshold, 1650 mV against 1651 mV). The converter model returns the loaded or the open-circuit value depending on `inhibit`, so a design that samples on the wrong side of the gate produces the wrong verdict.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam int unsigned MV_W = 12;

    typedef logic [MV_W-1:0] mv_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SETTLE,
        ST_OPEN,
        ST_EVAL
    } ct_state_e;

    typedef struct packed {
        logic ov;
        logic imp;
        logic done;
    } verdict_t;

    // true when hi lies strictly more than lim above lo
    function automatic logic gap_exceeds(input mv_t hi, input mv_t lo, input mv_t lim);
        return (hi > lo) && ((hi - lo) > lim);
    endfunction

endpackage

// File: rtl/ct_timers.sv
module ct_timers #(
    parameter int unsigned INTERVAL = 31,
    parameter int unsigned HOLDOFF  = 240,
    parameter int unsigned PLATEAU  = 960
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic peak_new,
    output logic test_due,
    output logic holdoff_act,
    output logic plateau_hit
);
    localparam int unsigned IW = $clog2(INTERVAL + 1);
    localparam int unsigned PW = $clog2(PLATEAU + 1);
    localparam logic [IW-1:0] I_LAST = IW'(INTERVAL - 1);
    localparam logic [PW-1:0] P_LIM  = PW'(PLATEAU);

    logic [IW-1:0] icnt;
    logic [PW-1:0] pcnt;

    // interval: a start is due on every INTERVAL-th tick since enable
    always_ff @(posedge clk) begin
        if (rst || !en)
            icnt <= '0;
        else if (tick)
            icnt <= (icnt == I_LAST) ? '0 : icnt + 1'b1;
    end
    assign test_due = en && tick && (icnt == I_LAST);

    // hold-off window after enable
    generate
        if (HOLDOFF == 0) begin : g_no_hold
            assign holdoff_act = 1'b0;
        end else begin : g_hold
            localparam int unsigned HW = $clog2(HOLDOFF + 1);
            localparam logic [HW-1:0] H_LIM = HW'(HOLDOFF);
            logic [HW-1:0] hcnt;
            always_ff @(posedge clk) begin
                if (rst || !en)
                    hcnt <= '0;
                else if (tick && hcnt < H_LIM)
                    hcnt <= hcnt + 1'b1;
            end
            assign holdoff_act = (hcnt < H_LIM);
        end
    endgenerate

    // plateau: ticks since the peak last rose
    always_ff @(posedge clk) begin
        if (rst || !en || peak_new)
            pcnt <= '0;
        else if (tick && pcnt < P_LIM)
            pcnt <= pcnt + 1'b1;
    end
    assign plateau_hit = (pcnt >= P_LIM);

endmodule

// File: rtl/ct_seq.sv
module ct_seq
    import ct_pkg::*;
#(
    parameter int unsigned SETTLE = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic test_due,
    input  logic smp_ready,
    input  mv_t  smp_mv,
    output logic smp_req,
    output logic inhibit,
    output logic eval,
    output mv_t  loaded_mv,
    output mv_t  open_mv
);
    localparam int unsigned SW = $clog2(SETTLE + 1);
    localparam logic [SW-1:0] S_LAST = SW'(SETTLE - 1);

    ct_state_e     state;
    logic [SW-1:0] scnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state     <= ST_IDLE;
            scnt      <= '0;
            loaded_mv <= '0;
            open_mv   <= '0;
        end else begin
            unique case (state)
                ST_IDLE:   if (test_due) state <= ST_LOAD;
                ST_LOAD:   if (smp_ready) begin
                               loaded_mv <= smp_mv;
                               state     <= ST_SETTLE;
                           end
                ST_SETTLE: if (tick) begin
                               if (scnt == S_LAST) begin
                                   scnt  <= '0;
                                   state <= ST_OPEN;
                               end else begin
                                   scnt <= scnt + 1'b1;
                               end
                           end
                ST_OPEN:   if (smp_ready) begin
                               open_mv <= smp_mv;
                               state   <= ST_EVAL;
                           end
                ST_EVAL:   state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign smp_req = (state == ST_LOAD) || (state == ST_OPEN);
    assign inhibit = (state == ST_SETTLE) || (state == ST_OPEN) || (state == ST_EVAL);
    assign eval    = (state == ST_EVAL);

endmodule

// File: rtl/ct_judge.sv
module ct_judge
    import ct_pkg::*;
#(
    parameter int unsigned DROP_MV = 2,
    parameter int unsigned OV_MV   = 1650
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic eval,
    input  mv_t  loaded_mv,
    input  mv_t  open_mv,
    input  mv_t  imp_thr_mv,
    input  logic holdoff_act,
    input  logic plateau_hit,
    output logic peak_new,
    output logic done_pulse,
    output logic imp_fail_pulse,
    output logic ov_fail_pulse
);
    localparam mv_t DROP_LIM = MV_W'(DROP_MV);
    localparam mv_t OV_LIM   = MV_W'(OV_MV);

    mv_t      peak_mv;
    logic     peak_valid;
    logic     rising;
    verdict_t raw, pick;

    assign rising   = !peak_valid || (open_mv > peak_mv);
    assign peak_new = eval && rising;

    always_comb begin
        raw.ov   = open_mv > OV_LIM;
        raw.imp  = gap_exceeds(loaded_mv, open_mv, imp_thr_mv);
        raw.done = !holdoff_act &&
                   ((peak_valid && gap_exceeds(peak_mv, open_mv, DROP_LIM)) ||
                    (plateau_hit && !rising));
        // over-voltage, then impedance, then completion
        pick      = '0;
        pick.ov   = raw.ov;
        pick.imp  = raw.imp && !raw.ov;
        pick.done = raw.done && !raw.ov && !raw.imp;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            peak_mv        <= '0;
            peak_valid     <= 1'b0;
            done_pulse     <= 1'b0;
            imp_fail_pulse <= 1'b0;
            ov_fail_pulse  <= 1'b0;
        end else begin
            done_pulse     <= eval && pick.done;
            imp_fail_pulse <= eval && pick.imp;
            ov_fail_pulse  <= eval && pick.ov;
            if (peak_new) begin
                peak_mv    <= open_mv;
                peak_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dv_cell_test.sv
module dv_cell_test
    import ct_pkg::*;
#(
    parameter int unsigned INTERVAL = 31,
    parameter int unsigned HOLDOFF  = 240,
    parameter int unsigned PLATEAU  = 960,
    parameter int unsigned SETTLE   = 1,
    parameter int unsigned DROP_MV  = 2,
    parameter int unsigned OV_MV    = 1650
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic [MV_W-1:0] imp_thr_mv,
    output logic            smp_req,
    input  logic            smp_ready,
    input  logic [MV_W-1:0] smp_mv,
    output logic            inhibit,
    output logic            done_pulse,
    output logic            imp_fail_pulse,
    output logic            ov_fail_pulse
);
    logic test_due, holdoff_act, plateau_hit, peak_new, eval;
    mv_t  loaded_mv, open_mv;

    ct_timers #(.INTERVAL(INTERVAL), .HOLDOFF(HOLDOFF), .PLATEAU(PLATEAU)) u_tmr (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .peak_new(peak_new),
        .test_due(test_due), .holdoff_act(holdoff_act), .plateau_hit(plateau_hit)
    );

    ct_seq #(.SETTLE(SETTLE)) u_seq (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .test_due(test_due),
        .smp_ready(smp_ready), .smp_mv(smp_mv), .smp_req(smp_req),
        .inhibit(inhibit), .eval(eval), .loaded_mv(loaded_mv), .open_mv(open_mv)
    );

    ct_judge #(.DROP_MV(DROP_MV), .OV_MV(OV_MV)) u_jdg (
        .clk(clk), .rst(rst), .en(en), .eval(eval),
        .loaded_mv(loaded_mv), .open_mv(open_mv), .imp_thr_mv(imp_thr_mv),
        .holdoff_act(holdoff_act), .plateau_hit(plateau_hit),
        .peak_new(peak_new), .done_pulse(done_pulse),
        .imp_fail_pulse(imp_fail_pulse), .ov_fail_pulse(ov_fail_pulse)
    );

endmodule

// File: rtl/dv_cell_test_chk.sv
module dv_cell_test_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic smp_req,
    input logic smp_ready,
    input logic inhibit,
    input logic done_pulse,
    input logic imp_fail_pulse,
    input logic ov_fail_pulse,
    input logic holdoff_act
);
    assert_one_verdict_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_pulse, imp_fail_pulse, ov_fail_pulse}));

    assert_pulse_at_release_R2: assert property (@(posedge clk) disable iff (rst)
        (done_pulse || imp_fail_pulse || ov_fail_pulse) |-> ($past(inhibit) && !inhibit));

    assert_gate_after_load_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(inhibit) |-> $past(smp_req && smp_ready));

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (smp_req && !smp_ready && en) |=> (smp_req || !en));

    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!inhibit && !smp_req && !done_pulse && !imp_fail_pulse && !ov_fail_pulse));

    assert_no_done_in_holdoff_R6: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> $past(!holdoff_act));
endmodule

bind dv_cell_test dv_cell_test_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .smp_req(smp_req), .smp_ready(smp_ready),
    .inhibit(inhibit), .done_pulse(done_pulse), .imp_fail_pulse(imp_fail_pulse),
    .ov_fail_pulse(ov_fail_pulse), .holdoff_act(holdoff_act)
);

// File: tb/sim_dv_cell_test.sv
`timescale 1ns/1ps
module sim_dv_cell_test;
    localparam int INTERVAL = 6;
    localparam int HOLDOFF  = 15;
    localparam int PLATEAU  = 30;
    localparam int SETTLE   = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        tick = 1'b0;
    logic [11:0] imp_thr_mv = 12'd50;
    logic        smp_req;
    logic        smp_ready = 1'b0;
    logic [11:0] smp_mv = '0;
    logic        inhibit, done_pulse, imp_fail_pulse, ov_fail_pulse;

    dv_cell_test #(.INTERVAL(INTERVAL), .HOLDOFF(HOLDOFF), .PLATEAU(PLATEAU),
                   .SETTLE(SETTLE)) u0 (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .imp_thr_mv(imp_thr_mv),
        .smp_req(smp_req), .smp_ready(smp_ready), .smp_mv(smp_mv),
        .inhibit(inhibit), .done_pulse(done_pulse),
        .imp_fail_pulse(imp_fail_pulse), .ov_fail_pulse(ov_fail_pulse)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int vload = 1400, vopen = 1400;
    int tdiv = 0, lat = 0;

    // time base: one tick every 4 clocks, driven just after the edge
    always @(posedge clk) begin
        #2;
        tdiv = (tdiv == 3) ? 0 : tdiv + 1;
        tick = (tdiv == 0);
    end

    // converter model: answers two cycles after a request
    always @(posedge clk) begin
        #2;
        if (smp_ready) begin
            smp_ready = 1'b0;
            lat = 0;
        end else if (smp_req) begin
            if (lat == 1) begin
                smp_ready = 1'b1;
                smp_mv = inhibit ? 12'(vopen) : 12'(vload);
                lat = 0;
            end else lat = lat + 1;
        end else lat = 0;
    end

    // monitor, sampled mid-cycle
    int  ticks_en = 0, nreq = 0, first_tick = 0, inh_tick = 0, settle_ticks = -1;
    int  start_prev = 0, start_last = 0;
    int  n_done = 0, n_imp = 0, n_ov = 0;
    logic inh0 = 1'b1, inh1 = 1'b0, req_q = 1'b0, inh_q = 1'b0;
    always @(negedge clk) begin
        if (!en) begin
            ticks_en = 0; nreq = 0;
        end else if (tick) ticks_en = ticks_en + 1;
        if (inhibit && !inh_q) inh_tick = ticks_en;
        if (smp_req && !req_q && en) begin
            if (nreq == 0) begin first_tick = ticks_en; inh0 = inhibit; end
            if (nreq == 1) inh1 = inhibit;
            if (!inhibit) begin start_prev = start_last; start_last = ticks_en; end
            else settle_ticks = ticks_en - inh_tick;
            nreq = nreq + 1;
        end
        req_q = smp_req;
        inh_q = inhibit;
        if (done_pulse) n_done = n_done + 1;
        if (imp_fail_pulse) n_imp = n_imp + 1;
        if (ov_fail_pulse) n_ov = n_ov + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic run_one(input int l, input int o, output int d, output int i, output int v);
        int d0, i0, v0;
        vload = l; vopen = o;
        d0 = n_done; i0 = n_imp; v0 = n_ov;
        while (!inhibit) step();
        while (inhibit) step();
        step();
        d = n_done - d0; i = n_imp - i0; v = n_ov - v0;
    endtask

    task automatic enable_on();
        step(); en = 1'b1;
    endtask

    task automatic enable_off();
        step(); en = 1'b0;
        repeat (3) step();
    endtask

    task automatic t_reset();
        repeat (3) step();
        check("R11 req in reset", smp_req, 0);
        check("R11 inhibit in reset", inhibit, 0);
        check("R11 pulses in reset", done_pulse | imp_fail_pulse | ov_fail_pulse, 0);
        rst = 1'b0;
        step();
        check("R11 idle after reset", smp_req | inhibit, 0);
    endtask

    task automatic t_first();
        int d, i, v;
        imp_thr_mv = 12'd50;
        enable_on();
        run_one(1400, 1400, d, i, v);
        check("R1 first test tick", first_tick, INTERVAL);
        check("R2 loaded sample ungated", inh0, 0);
        check("R2 open sample gated", inh1, 1);
        check("R2 settle ticks", settle_ticks, SETTLE);
        check("R3 handshake test completes", d + i + v, 0);
        run_one(1400, 1400, d, i, v);
        check("R1 test spacing", start_last - start_prev, INTERVAL);
        enable_off();
    endtask

    task automatic t_drop();
        int d, i, v;
        enable_on();
        run_one(1400, 1400, d, i, v);
        run_one(1390, 1390, d, i, v);
        check("R6 drop held off", d, 0);
        run_one(1399, 1399, d, i, v);
        check("R4 drop 1 mV", d, 0);
        run_one(1398, 1398, d, i, v);
        check("R4 drop 2 mV", d, 0);
        run_one(1397, 1397, d, i, v);
        check("R4 drop 3 mV", d, 1);
        enable_off();
    endtask

    task automatic t_plateau();
        int d, i, v, first, early;
        enable_on();
        first = 0; early = 0;
        for (int k = 1; k <= 7; k++) begin
            run_one(1300, 1300, d, i, v);
            if (d != 0 && k <= 5) early++;
            if (d != 0 && first == 0) first = k;
        end
        check("R5 no plateau end early", early, 0);
        check("R5 plateau end reached", (first == 6 || first == 7) ? 1 : 0, 1);
        enable_off();
        enable_on();
        early = 0;
        for (int k = 0; k < 9; k++) begin
            run_one(1300 + k, 1300 + k, d, i, v);
            early += d;
        end
        check("R5 rising readings never end", early, 0);
        enable_off();
    endtask

    task automatic t_imp();
        int d, i, v;
        imp_thr_mv = 12'd50;
        enable_on();
        run_one(1450, 1400, d, i, v);
        check("R7 gap equal to threshold", i, 0);
        run_one(1451, 1400, d, i, v);
        check("R7 gap over threshold", i, 1);
        enable_off();
    endtask

    task automatic t_ov();
        int d, i, v;
        enable_on();
        run_one(1700, 1650, d, i, v);
        check("R8 open at limit, loaded high", v, 0);
        run_one(1651, 1651, d, i, v);
        check("R8 open above limit", v, 1);
        enable_off();
    endtask

    task automatic t_prio();
        int d, i, v;
        enable_on();
        run_one(1400, 1400, d, i, v);
        run_one(1400, 1400, d, i, v);
        run_one(1490, 1390, d, i, v);
        check("R9 impedance beats done: imp", i, 1);
        check("R9 impedance beats done: done", d, 0);
        run_one(1395, 1390, d, i, v);
        check("R9 done alone", d, 1);
        run_one(1800, 1700, d, i, v);
        check("R9 over-voltage beats impedance", v * 10 + i + d, 10);
        enable_off();
    endtask

    task automatic t_clear();
        int d, i, v, sum;
        enable_on();
        run_one(1500, 1500, d, i, v);
        run_one(1500, 1500, d, i, v);
        enable_off();
        enable_on();
        sum = 0;
        for (int k = 0; k < 3; k++) begin
            run_one(1450, 1450, d, i, v);
            sum += d;
        end
        check("R10 peak cleared by disable", sum, 0);
        enable_off();
        enable_on();
        while (!inhibit) step();
        en = 1'b0;
        step();
        check("R10 test abandoned", inhibit | smp_req, 0);
        repeat (3) step();
    endtask

    bit finished = 0;

    initial begin
        t_reset();
        t_first();
        t_drop();
        t_plateau();
        t_imp();
        t_ov();
        t_prio();
        t_clear();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule